// File: doc/BRIEF.md
# Door Lock Output Controller

This block turns one-cycle unlock requests into a drive enable for a single door lock output. Before it energizes, a request must pass four gates in a fixed order. First the controller must be idle. Second, no stuck-output suspicion may be latched. Third, the tamper policy must allow it. Fourth, the energized-time budget must have room. Each request produces exactly one decision strobe that carries a 3-bit result code. An unlock ends on a relock command or at a programmable on-time limit, whichever comes first. The limit is enforced in hardware, so a firmware fault cannot hold the lock energized.

Every time the drive goes off, the controller records two findings. The first is whether the door contact showed an open transition during the on-time. The second, taken after a programmable check window, is whether the external load-current comparator still reports current. If current remains, a stuck-output suspicion is latched. That suspicion blocks every later unlock until a service clear is given while the current indication is low. Only a power-on reset clears it otherwise. All times are counted in clock ticks against limits supplied on configuration inputs.

Result codes: 0 allowed, 1 refused by tamper policy, 2 refused because stuck, 3 refused by duty budget, 4 on-time limit reached, 5 no door-open transition, 6 busy.

Top module: `door_lock_ctrl`

## Requirements
- R1: After reset the drive is off and the overtime flag, the no-door flag and all strobes are low. rst_n (synchronous, active low) leaves the stuck flag unchanged. por_n (synchronous, active low) clears everything, the stuck flag included.
- R2: A request that is accepted while idle raises drive_en_o at the clock edge that samples it. At that same edge it emits dec_vld_o with code 0.
- R3: A relock command ends the drive at the edge that samples it. With no relock, the drive stays high for exactly cfg_on_max_i cycles and then falls. That fall emits diag code 4 and sets overtime_o, even if the door was opened.
- R4: If no door-open rising edge was sampled during the on-time, diag code 5 is emitted one cycle after the drive falls and nodoor_o is set. If the door opened, nodoor_o is cleared and no code 5 is emitted.
- R5: If load_on_i is high when the check window ends, stuck_o is set. The window ends cfg_chk_win_i cycles after the drive falls.
- R6: While stuck_o is set, every request is refused with code 2 and dec_hipri_o high, and the drive stays off.
- R7: svc_clear_i clears stuck_o only when load_on_i is low. With load_on_i high it has no effect.
- R8: In lockdown mode (policy_i 2 or 3) with tamper_i high, every request is refused with code 1.
- R9: In degrade mode (policy_i 1) with tamper_i high, local requests are allowed and remote requests (req_remote_i high) are refused with code 1.
- R10: In record-only mode (policy_i 0) all requests pass the tamper gate. tamper_evt_o pulses for one cycle after every change of tamper_i, in every mode.
- R11: A request is refused with code 3 if the energized cycles counted in the current budget window, plus cfg_on_max_i, exceed cfg_duty_cap_i. The count restarts every cfg_duty_win_i cycles after reset.
- R12: A request that arrives while the drive is on, or during the check window, gets code 6. It does not extend the on-time.
- R13: Refusal causes have a fixed priority: busy first, then stuck, then policy, then duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; keeps the stuck flag |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| req_i | input | 1 | One-cycle unlock request |
| req_remote_i | input | 1 | Request comes from a remote source (1) or a local one (0) |
| relock_i | input | 1 | Ends the current unlock |
| tamper_i | input | 1 | Debounced tamper state |
| policy_i | input | 2 | Tamper policy: 0 record-only, 1 degrade, 2 or 3 lockdown |
| door_open_i | input | 1 | Door contact, 1 = open |
| load_on_i | input | 1 | Load current present, from an external comparator |
| svc_clear_i | input | 1 | Service clear of the stuck flag |
| cfg_on_max_i | input | TW | Maximum on-time in cycles |
| cfg_chk_win_i | input | TW | Check window after OFF in cycles (at least 1) |
| cfg_duty_win_i | input | TW | Budget window length in cycles (at least 1) |
| cfg_duty_cap_i | input | TW | Energized cycles allowed per budget window |
| drive_en_o | output | 1 | Lock drive enable |
| stuck_o | output | 1 | Stuck-output suspicion |
| overtime_o | output | 1 | Last unlock hit the on-time limit |
| nodoor_o | output | 1 | Last unlock saw no door opening |
| dec_vld_o | output | 1 | Decision strobe |
| dec_code_o | output | 3 | Decision result code |
| dec_hipri_o | output | 1 | Decision is high priority |
| diag_vld_o | output | 1 | Diagnostic strobe |
| diag_code_o | output | 3 | Diagnostic result code |
| tamper_evt_o | output | 1 | Tamper state changed |

## Verification
A wrong on-time counter shows up as drive_en_o falling one or more cycles early or late, and the diag code 4 strobe moves with it. A wrong door-edge or stuck latch shows up in the next strobe that follows: code 5 missing or extra one cycle after the drive falls, or a code 2 refusal missing on the next request. A corrupted gate order or duty count is visible within one cycle of the following request, because the code on dec_code_o is wrong. The bench queues the expected codes ahead of each stimulus and compares each strobe in the cycle it appears.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [2:0] {
        RES_ALLOW       = 3'd0,
        RES_DENY_POLICY = 3'd1,
        RES_DENY_STUCK  = 3'd2,
        RES_DENY_DUTY   = 3'd3,
        RES_TIMEOUT     = 3'd4,
        RES_NO_DOOR     = 3'd5,
        RES_BUSY        = 3'd6
    } res_e;

    localparam logic [1:0] POL_RECORD  = 2'd0;
    localparam logic [1:0] POL_DEGRADE = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_CHECK = 2'd2
    } st_e;

endpackage

// File: rtl/lock_req_gate.sv
module lock_req_gate
    import lock_pkg::*;
(
    input  logic       busy_i,
    input  logic       stuck_i,
    input  logic       tamper_i,
    input  logic [1:0] policy_i,
    input  logic       remote_i,
    input  logic       duty_ok_i,
    output res_e       code_o,
    output logic       hipri_o
);

    logic pol_block;

    // bit 1 set selects lockdown; degrade blocks only remote sources
    always_comb begin
        pol_block = tamper_i && (policy_i[1] || (policy_i == POL_DEGRADE && remote_i));
    end

    always_comb begin
        hipri_o = 1'b0;
        if (busy_i) begin
            code_o = RES_BUSY;
        end else if (stuck_i) begin
            code_o  = RES_DENY_STUCK;
            hipri_o = 1'b1;
        end else if (pol_block) begin
            code_o = RES_DENY_POLICY;
        end else if (!duty_ok_i) begin
            code_o = RES_DENY_DUTY;
        end else begin
            code_o = RES_ALLOW;
        end
    end

endmodule

// File: rtl/lock_duty_meter.sv
module lock_duty_meter #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          drive_i,
    input  logic [TW-1:0] cfg_win_i,
    input  logic [TW-1:0] cfg_cap_i,
    input  logic [TW-1:0] cfg_on_max_i,
    output logic          duty_ok_o
);

    localparam int UW = TW + 1;
    localparam int SW = TW + 2;

    typedef struct packed {
        logic [TW-1:0] win;
        logic [UW-1:0] used;
    } duty_t;

    duty_t         d, q;
    logic [SW-1:0] need;

    always_comb begin
        d = q;
        if (q.win >= cfg_win_i - TW'(1)) begin
            d.win  = '0;
            d.used = '0;
        end else begin
            d.win = q.win + TW'(1);
            if (drive_i) d.used = q.used + UW'(1);
        end
    end

    always_comb begin
        need      = SW'(q.used) + SW'(cfg_on_max_i);
        duty_ok_o = (need <= SW'(cfg_cap_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) q <= '0;
        else                  q <= d;
    end

    // R11: admission keeps the window count inside the cap
    a_r11_used_within_cap: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        q.used <= UW'(cfg_cap_i));

endmodule

// File: rtl/lock_stuck_latch.sv
module lock_stuck_latch (
    input  logic clk,
    input  logic por_n,
    input  logic chk_end_i,
    input  logic load_on_i,
    input  logic svc_clear_i,
    output logic stuck_o
);

    logic stuck_d, stuck_q;

    always_comb begin
        stuck_d = stuck_q;
        if (svc_clear_i && !load_on_i) stuck_d = 1'b0;
        if (chk_end_i && load_on_i)    stuck_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!por_n) stuck_q <= 1'b0;
        else        stuck_q <= stuck_d;
    end

    assign stuck_o = stuck_q;

    a_r5_stuck_set: assert property (@(posedge clk) disable iff (!por_n)
        chk_end_i && load_on_i |=> stuck_q);

    a_r7_stuck_hold: assert property (@(posedge clk) disable iff (!por_n)
        stuck_q && !svc_clear_i |=> stuck_q);

endmodule

// File: rtl/door_lock_ctrl.sv
module door_lock_ctrl
    import lock_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          req_i,
    input  logic          req_remote_i,
    input  logic          relock_i,
    input  logic          tamper_i,
    input  logic [1:0]    policy_i,
    input  logic          door_open_i,
    input  logic          load_on_i,
    input  logic          svc_clear_i,
    input  logic [TW-1:0] cfg_on_max_i,
    input  logic [TW-1:0] cfg_chk_win_i,
    input  logic [TW-1:0] cfg_duty_win_i,
    input  logic [TW-1:0] cfg_duty_cap_i,
    output logic          drive_en_o,
    output logic          stuck_o,
    output logic          overtime_o,
    output logic          nodoor_o,
    output logic          dec_vld_o,
    output logic [2:0]    dec_code_o,
    output logic          dec_hipri_o,
    output logic          diag_vld_o,
    output logic [2:0]    diag_code_o,
    output logic          tamper_evt_o
);

    typedef struct packed {
        st_e           st;
        logic          drive;
        logic [TW-1:0] on_cnt;
        logic [TW-1:0] chk_cnt;
        logic          seen;
        logic          door_prev;
        logic          tamper_prev;
        logic          tamper_evt;
        logic          dec_vld;
        res_e          dec_code;
        logic          dec_hipri;
        logic          diag_vld;
        res_e          diag_code;
        logic          pend_nodoor;
        logic          overtime;
        logic          nodoor;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic stuck, duty_ok, busy, door_rise, timeout_hit, off_now, chk_end, gate_hipri;
    res_e gate_code;

    always_comb begin
        busy        = (ctl_q.st != ST_IDLE);
        door_rise   = door_open_i && !ctl_q.door_prev;
        timeout_hit = (ctl_q.st == ST_ON) && !relock_i && (ctl_q.on_cnt >= cfg_on_max_i);
        off_now     = (ctl_q.st == ST_ON) && (relock_i || timeout_hit);
        chk_end     = (ctl_q.st == ST_CHECK) && (ctl_q.chk_cnt >= cfg_chk_win_i);
    end

    lock_req_gate i_gate (
        .busy_i    (busy),
        .stuck_i   (stuck),
        .tamper_i  (tamper_i),
        .policy_i  (policy_i),
        .remote_i  (req_remote_i),
        .duty_ok_i (duty_ok),
        .code_o    (gate_code),
        .hipri_o   (gate_hipri)
    );

    lock_duty_meter #(.TW(TW)) i_duty (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_n        (por_n),
        .drive_i      (ctl_q.drive),
        .cfg_win_i    (cfg_duty_win_i),
        .cfg_cap_i    (cfg_duty_cap_i),
        .cfg_on_max_i (cfg_on_max_i),
        .duty_ok_o    (duty_ok)
    );

    lock_stuck_latch i_stuck (
        .clk         (clk),
        .por_n       (por_n),
        .chk_end_i   (chk_end),
        .load_on_i   (load_on_i),
        .svc_clear_i (svc_clear_i),
        .stuck_o     (stuck)
    );

    always_comb begin
        ctl_d             = ctl_q;
        ctl_d.door_prev   = door_open_i;
        ctl_d.tamper_prev = tamper_i;
        ctl_d.tamper_evt  = tamper_i ^ ctl_q.tamper_prev;
        ctl_d.dec_vld     = 1'b0;
        ctl_d.dec_hipri   = 1'b0;
        ctl_d.diag_vld    = 1'b0;

        // diagnostic owed from the previous OFF edge
        if (ctl_q.pend_nodoor) begin
            ctl_d.diag_vld    = 1'b1;
            ctl_d.diag_code   = RES_NO_DOOR;
            ctl_d.pend_nodoor = 1'b0;
        end

        if (req_i) begin
            ctl_d.dec_vld   = 1'b1;
            ctl_d.dec_code  = gate_code;
            ctl_d.dec_hipri = gate_hipri;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i && gate_code == RES_ALLOW) begin
                    ctl_d.st     = ST_ON;
                    ctl_d.drive  = 1'b1;
                    ctl_d.on_cnt = TW'(1);
                    ctl_d.seen   = 1'b0;
                end
            end
            ST_ON: begin
                if (door_rise) ctl_d.seen = 1'b1;
                if (off_now) begin
                    ctl_d.st          = ST_CHECK;
                    ctl_d.drive       = 1'b0;
                    ctl_d.chk_cnt     = TW'(1);
                    ctl_d.overtime    = timeout_hit;
                    ctl_d.nodoor      = !(ctl_q.seen || door_rise);
                    ctl_d.pend_nodoor = !(ctl_q.seen || door_rise);
                    if (timeout_hit) begin
                        ctl_d.diag_vld  = 1'b1;
                        ctl_d.diag_code = RES_TIMEOUT;
                    end
                end else begin
                    ctl_d.on_cnt = ctl_q.on_cnt + TW'(1);
                end
            end
            ST_CHECK: begin
                if (chk_end) ctl_d.st = ST_IDLE;
                else         ctl_d.chk_cnt = ctl_q.chk_cnt + TW'(1);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= ST_IDLE;
            ctl_q.dec_code  <= RES_ALLOW;
            ctl_q.diag_code <= RES_ALLOW;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drive_en_o   = ctl_q.drive;
    assign stuck_o      = stuck;
    assign overtime_o   = ctl_q.overtime;
    assign nodoor_o     = ctl_q.nodoor;
    assign dec_vld_o    = ctl_q.dec_vld;
    assign dec_code_o   = ctl_q.dec_code;
    assign dec_hipri_o  = ctl_q.dec_hipri;
    assign diag_vld_o   = ctl_q.diag_vld;
    assign diag_code_o  = ctl_q.diag_code;
    assign tamper_evt_o = ctl_q.tamper_evt;

    a_r3_timeout_off: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ctl_q.diag_vld && ctl_q.diag_code == RES_TIMEOUT |-> !ctl_q.drive && $past(ctl_q.drive));

    a_r6_stuck_blocks: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        stuck && !ctl_q.drive |=> !ctl_q.drive);

    a_r12_busy_result: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        busy && req_i |=> ctl_q.dec_vld && ctl_q.dec_code == RES_BUSY);

    a_r8_lockdown_refuses: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !busy && !stuck && req_i && tamper_i && policy_i[1]
        |=> ctl_q.dec_code == RES_DENY_POLICY && !ctl_q.drive);

endmodule

// File: tb/test_door_lock_ctrl.sv
module test_door_lock_ctrl;

    localparam int TW     = 16;
    localparam int CLK_NS = 10;

    typedef struct {
        int    code;
        int    hipri;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, por_n = 1'b0;
    logic          req = 1'b0, remote = 1'b0, relock = 1'b0, tamper = 1'b0;
    logic [1:0]    policy = 2'd0;
    logic          door = 1'b0, load_on = 1'b0, svc = 1'b0;
    logic [TW-1:0] on_max = TW'(4), chk_win = TW'(3), duty_win = TW'(400), duty_cap = TW'(100);
    logic          drive, stuck, overtime, nodoor, dec_vld, dec_hipri, diag_vld, tevt;
    logic [2:0]    dec_code, diag_code;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    exp_t q_dec[$];
    exp_t q_diag[$];

    always #(CLK_NS/2) clk = ~clk;

    door_lock_ctrl #(.TW(TW)) i_door_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_i(req), .req_remote_i(remote),
        .relock_i(relock), .tamper_i(tamper), .policy_i(policy), .door_open_i(door),
        .load_on_i(load_on), .svc_clear_i(svc), .cfg_on_max_i(on_max),
        .cfg_chk_win_i(chk_win), .cfg_duty_win_i(duty_win), .cfg_duty_cap_i(duty_cap),
        .drive_en_o(drive), .stuck_o(stuck), .overtime_o(overtime), .nodoor_o(nodoor),
        .dec_vld_o(dec_vld), .dec_code_o(dec_code), .dec_hipri_o(dec_hipri),
        .diag_vld_o(diag_vld), .diag_code_o(diag_code), .tamper_evt_o(tevt)
    );

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver: queue the expected decision, then pulse the request
    task automatic request(bit rem, int code, int hipri, string tag);
        exp_t e;
        e.code = code; e.hipri = hipri; e.tag = tag;
        q_dec.push_back(e);
        @(posedge clk); #1;
        req = 1'b1; remote = rem;
        @(posedge clk); #1;
        req = 1'b0; remote = 1'b0;
    endtask

    task automatic expect_diag(int code, string tag);
        exp_t e;
        e.code = code; e.hipri = 0; e.tag = tag;
        q_diag.push_back(e);
    endtask

    // monitor: compare strobes against the queues away from the edge
    always @(negedge clk) begin
        if (dec_vld) begin
            if (q_dec.size() == 0) begin
                check_eq("R2 unexpected decision", int'(dec_code), -1);
            end else begin
                exp_t e;
                e = q_dec.pop_front();
                check_eq({e.tag, " decision code"}, int'(dec_code), e.code);
                check_eq({e.tag, " hipri"}, int'(dec_hipri), e.hipri);
            end
        end
        if (diag_vld) begin
            if (q_diag.size() == 0) begin
                check_eq("R4 unexpected diag", int'(diag_code), -1);
            end else begin
                exp_t e;
                e = q_diag.pop_front();
                check_eq({e.tag, " diag code"}, int'(diag_code), e.code);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick(3);
        rst_n = 1'b1; por_n = 1'b1;
        tick(1);
        check_eq("R1 drive", drive, 0);
        check_eq("R1 stuck", stuck, 0);
        check_eq("R1 overtime", overtime, 0);
        check_eq("R1 nodoor", nodoor, 0);
        check_eq("R1 dec_vld", dec_vld, 0);

        // R2/R3/R4: allowed unlock, door opens, relock ends it
        request(1'b0, 0, 0, "R2");
        check_eq("R2 drive on", drive, 1);
        door = 1'b1;
        tick(1);
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        check_eq("R3 relock off", drive, 0);
        check_eq("R4 door seen", nodoor, 0);
        check_eq("R3 no overtime", overtime, 0);
        door = 1'b0;
        tick(5);

        // R3/R4: on-time limit, door never opened
        expect_diag(4, "R3");
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R2");
        tick(3);
        check_eq("R3 still on at limit-1", drive, 1);
        tick(1);
        check_eq("R3 off at limit", drive, 0);
        check_eq("R3 overtime flag", overtime, 1);
        check_eq("R4 nodoor flag", nodoor, 1);
        tick(5);

        // R12: requests during on-time and during check window
        expect_diag(4, "R12");
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R2");
        request(1'b0, 6, 0, "R12");
        tick(1);
        check_eq("R12 on-time not extended (on)", drive, 1);
        tick(1);
        check_eq("R12 on-time not extended (off)", drive, 0);
        request(1'b0, 6, 0, "R12");
        tick(5);

        // R5/R6/R7: current persists after OFF
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R2");
        load_on = 1'b1;
        tick(1);
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        tick(2);
        check_eq("R5 stuck not before window end", stuck, 0);
        tick(1);
        check_eq("R5 stuck set", stuck, 1);
        request(1'b0, 2, 1, "R6");
        tick(1);
        check_eq("R6 drive held off", drive, 0);
        svc = 1'b1;
        tick(1);
        svc = 1'b0;
        check_eq("R7 clear ignored with current", stuck, 1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check_eq("R1 stuck kept through rst_n", stuck, 1);
        load_on = 1'b0;
        svc = 1'b1;
        tick(1);
        svc = 1'b0;
        check_eq("R7 clear with no current", stuck, 0);

        // R8/R10: lockdown
        policy = 2'd2;
        tamper = 1'b1;
        tick(1);
        check_eq("R10 tamper event on set", tevt, 1);
        request(1'b0, 1, 0, "R8");
        request(1'b1, 1, 0, "R8");
        policy = 2'd3;
        request(1'b0, 1, 0, "R8");
        tick(1);
        check_eq("R8 drive off", drive, 0);

        // R9: degrade
        policy = 2'd1;
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R9");
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        tick(5);
        request(1'b1, 1, 0, "R9");

        // R10: record-only
        policy = 2'd0;
        expect_diag(5, "R4");
        request(1'b1, 0, 0, "R10");
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        tick(5);
        tamper = 1'b0;
        tick(1);
        check_eq("R10 tamper event on clear", tevt, 1);
        tick(1);
        check_eq("R10 tamper event one cycle", tevt, 0);

        // R13: busy outranks lockdown
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R2");
        tamper = 1'b1; policy = 2'd2;
        request(1'b0, 6, 0, "R13");
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        tick(5);
        tamper = 1'b0; policy = 2'd0;

        // R11: duty budget with a restarted window
        rst_n = 1'b0;
        duty_cap = TW'(6);
        tick(2);
        rst_n = 1'b1;
        expect_diag(4, "R3");
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R11");
        tick(9);
        request(1'b0, 3, 0, "R11");
        tamper = 1'b1; policy = 2'd2;
        request(1'b0, 1, 0, "R13");
        tamper = 1'b0; policy = 2'd0;
        tick(400);
        expect_diag(5, "R4");
        request(1'b0, 0, 0, "R11");
        relock = 1'b1;
        tick(1);
        relock = 1'b0;
        tick(6);

        check_eq("R2 decisions all seen", q_dec.size(), 0);
        check_eq("R4 diagnostics all seen", q_diag.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule